// File: doc/BRIEF.md
# Peripheral Window Address Translator

This block takes one access request at a time, described by an address space (port I/O, memory or firmware), a 32-bit address, a byte count and a read/write flag. It decides whether the access fits its window. If it does, it produces the matching peripheral-bus address by adding a fixed base for that space. Firmware space is divided into 256 MB segments. The host controller selects the active segment through a 4-bit field. For reads it also needs the fetch width in a separate register. The block keeps its own copy of both values. It emits a configuration write only when a value has to change, and it emits those writes before it releases the result of the access.

All three interfaces use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a new request is held off until the previous response has been taken. A configuration write or a response, once raised, keeps its valid and its payload unchanged until the matching ready is seen high on a clock edge. Space codes are 0 for I/O, 1 for memory, 2 for firmware and 3 for reserved.

Top module: `lpc_window_xlate`

## Requirements
- R1: A request whose address plus size reaches or exceeds 2^32 is rejected (`rsp_ok`=0, `rsp_addr`=0).
- R2: I/O space (code 0) accepts only size 1 with address+size ≤ 0x10000, and translates to 0xD0010000 + address.
- R3: Memory space (code 1) accepts only size 1 with address+size ≤ 0x10000000, and translates to 0xE0000000 + address.
- R4: Firmware space (code 2) accepts a request only if its last byte has the same address bits 31:28 as its first byte, and translates to 0xF0000000 + address (modulo 2^32).
- R5: Firmware space accepts sizes 1, 2 and 4 only. Any other size is rejected.
- R6: An accepted firmware access whose segment (address bits 31:28) differs from the cached segment first issues a configuration write with address 0xC0012024, data = segment in bits 3:0, and mask 0x0000000F so that bits 31:4 are preserved. When the segment matches the cache, this write is skipped.
- R7: An accepted firmware read whose size differs from the cached read size issues a configuration write with address 0xC0012028, mask 0xFFFFFFFF and data 0x00000000, 0x01000000 or 0x02000000 for sizes 1, 2 or 4. Firmware writes never issue it and never change that cache.
- R8: When both configuration writes are needed, the segment write comes first, then the read-size write, then the response.
- R9: Reserved space and every rejected request produce a response with no configuration write and no change to either cache.
- R10: After reset, `req_ready` is 1, `cfg_valid` and `rsp_valid` are 0, and both caches hold the invalid value 0xFF. The first accepted firmware read therefore issues both writes.
- R11: `req_ready` stays low from acceptance until the response handshake. A stalled `cfg_*` or `rsp_*` output stays valid and unchanged until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_space | input | 2 | Space code: 0 I/O, 1 memory, 2 firmware, 3 reserved |
| req_addr | input | 32 | Byte address inside the space |
| req_size | input | 3 | Byte count |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cfg_valid | output | 1 | Configuration write pending |
| cfg_ready | input | 1 | Configuration write taken |
| cfg_addr | output | 32 | Controller register address |
| cfg_data | output | 32 | Value to write |
| cfg_mask | output | 32 | Bits of `cfg_data` to apply; other bits are kept |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_ok | output | 1 | 1 if the request was accepted |
| rsp_addr | output | 32 | Translated peripheral address, 0 on reject |

## Verification
Each output is due at a fixed point after its cause. The first configuration write, or the response when no write is needed, is valid the cycle after the request handshake. Each following item is valid the cycle after the handshake before it. The bench drives both readies and samples every output on the falling edge. It records a handshake only when it sees valid and the ready it has just set, and it compares a stalled item with its value on the previous falling edge. A reference cache model kept in the bench predicts the exact list of configuration writes for a sweep over all space codes, all sizes 0 to 7, reads and writes, and boundary addresses, run both with and without back-pressure.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;
  typedef enum logic [1:0] {
    SP_IO  = 2'd0,
    SP_MEM = 2'd1,
    SP_FW  = 2'd2,
    SP_RSV = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_RSZ  = 2'd2,
    ST_RESP = 2'd3
  } state_e;

  localparam int unsigned CACHE_W = 8;
  localparam logic [CACHE_W-1:0] CACHE_INVALID = 8'hFF;
endpackage

// File: rtl/lpcw_check.sv
module lpcw_check
  import lpcw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned SIZE_W        = 3,
  parameter int unsigned IO_SPAN_LOG2  = 16,
  parameter int unsigned MEM_SPAN_LOG2 = 28,
  parameter int unsigned SEG_LOG2      = 28,
  parameter logic [ADDR_W-1:0] IO_BASE  = 'hD001_0000,
  parameter logic [ADDR_W-1:0] MEM_BASE = 'hE000_0000,
  parameter logic [ADDR_W-1:0] FW_BASE  = 'hF000_0000,
  localparam int unsigned SEG_W = ADDR_W - SEG_LOG2
) (
  input  logic [1:0]        space,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              ok,
  output logic [ADDR_W-1:0] xaddr,
  output logic [SEG_W-1:0]  seg
);
  localparam logic [ADDR_W:0] IO_LIMIT  = (ADDR_W+1)'(1) << IO_SPAN_LOG2;
  localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(1) << MEM_SPAN_LOG2;

  logic [ADDR_W:0]   top;
  logic [ADDR_W-1:0] last;
  logic              wrap, byte_only, fw_size, seg_same;
  logic [ADDR_W-1:0] base;

  always_comb begin
    top       = {1'b0, addr} + (ADDR_W+1)'(size);
    wrap      = top[ADDR_W];
    last      = top[ADDR_W-1:0] - ADDR_W'(1);
    byte_only = (size == SIZE_W'(1));
    fw_size   = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) || (size == SIZE_W'(4));
    seg       = addr[ADDR_W-1:SEG_LOG2];
    seg_same  = (last[ADDR_W-1:SEG_LOG2] == seg);
    ok        = 1'b0;
    base      = '0;
    case (space_e'(space))
      SP_IO:  begin ok = byte_only && (top <= IO_LIMIT);  base = IO_BASE;  end
      SP_MEM: begin ok = byte_only && (top <= MEM_LIMIT); base = MEM_BASE; end
      SP_FW:  begin ok = fw_size && seg_same;             base = FW_BASE;  end
      default: begin ok = 1'b0; base = '0; end
    endcase
    if (wrap) ok = 1'b0;
    xaddr = ok ? (base + addr) : '0;
  end

  always_comb begin
    if (wrap) assert_wrap_reject_R1: assert (!ok);
    if (ok && space == SP_IO)
      assert_io_window_R2: assert (xaddr[ADDR_W-1:IO_SPAN_LOG2] == IO_BASE[ADDR_W-1:IO_SPAN_LOG2]);
    if (ok && space == SP_FW) assert_fw_size_R5: assert ($countones(size) == 1);
    if (space == SP_RSV) assert_rsv_reject_R9: assert (!ok);
  end
endmodule

// File: rtl/lpcw_cfg_cache.sv
module lpcw_cfg_cache
  import lpcw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SIZE_W  = 3,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned RSZ_LSB = 24,
  parameter logic [ADDR_W-1:0] REG_BASE = 'hC001_2000,
  parameter logic [ADDR_W-1:0] SEG_OFS  = 'h24,
  parameter logic [ADDR_W-1:0] RSZ_OFS  = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  seg_want,
  input  logic [SIZE_W-1:0] rsz_want,
  input  logic              seg_load,
  input  logic              rsz_load,
  input  logic              sel_rsz,
  output logic              seg_need,
  output logic              rsz_need,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [ADDR_W-1:0] cfg_data,
  output logic [ADDR_W-1:0] cfg_mask
);
  localparam logic [ADDR_W-1:0] SEG_ADDR = REG_BASE + SEG_OFS;
  localparam logic [ADDR_W-1:0] RSZ_ADDR = REG_BASE + RSZ_OFS;
  localparam logic [ADDR_W-1:0] SEG_MASK = (ADDR_W'(1) << SEG_W) - ADDR_W'(1);

  logic [CACHE_W-1:0] seg_cache, rsz_cache;
  logic [1:0]         rsz_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_cache <= CACHE_INVALID;
      rsz_cache <= CACHE_INVALID;
    end else begin
      if (seg_load) seg_cache <= CACHE_W'(seg_want);
      if (rsz_load) rsz_cache <= CACHE_W'(rsz_want);
    end
  end

  always_comb begin
    seg_need = (seg_cache != CACHE_W'(seg_want));
    rsz_need = (rsz_cache != CACHE_W'(rsz_want));
    case (rsz_want)
      SIZE_W'(2): rsz_code = 2'd1;
      SIZE_W'(4): rsz_code = 2'd2;
      default:    rsz_code = 2'd0;
    endcase
    if (sel_rsz) begin
      cfg_addr = RSZ_ADDR;
      cfg_data = ADDR_W'(rsz_code) << RSZ_LSB;
      cfg_mask = '1;
    end else begin
      cfg_addr = SEG_ADDR;
      cfg_data = ADDR_W'(seg_want);
      cfg_mask = SEG_MASK;
    end
  end

  assert_seg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsz_load |-> (seg_cache == CACHE_W'(seg_want)));
  assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_load && rsz_load));
endmodule

// File: rtl/lpcw_seq.sv
module lpcw_seq
  import lpcw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned SEG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_space,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic              chk_ok,
  input  logic [ADDR_W-1:0] chk_xaddr,
  input  logic [SEG_W-1:0]  chk_seg,
  input  logic              seg_need,
  input  logic              rsz_need,
  input  logic              cfg_ready,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              cfg_valid,
  output logic              sel_rsz,
  output logic              seg_load,
  output logic              rsz_load,
  output logic [SEG_W-1:0]  want_seg,
  output logic [SIZE_W-1:0] want_size,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_addr
);
  state_e            state, state_nx;
  logic              held_fw, held_write;
  logic [SEG_W-1:0]  held_seg;
  logic [SIZE_W-1:0] held_size;
  logic              take, in_fw;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign in_fw     = (req_space == SP_FW);
  assign cfg_valid = (state == ST_SEG) || (state == ST_RSZ);
  assign sel_rsz   = (state == ST_RSZ);
  assign rsp_valid = (state == ST_RESP);
  assign seg_load  = (state == ST_SEG) && cfg_ready;
  assign rsz_load  = (state == ST_RSZ) && cfg_ready;
  assign want_seg  = (state == ST_IDLE) ? chk_seg  : held_seg;
  assign want_size = (state == ST_IDLE) ? req_size : held_size;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (req_valid) begin
        if (!chk_ok || !in_fw)             state_nx = ST_RESP;
        else if (seg_need)                 state_nx = ST_SEG;
        else if (!req_write && rsz_need)   state_nx = ST_RSZ;
        else                               state_nx = ST_RESP;
      end
      ST_SEG:  if (cfg_ready) state_nx = (!held_write && rsz_need) ? ST_RSZ : ST_RESP;
      ST_RSZ:  if (cfg_ready) state_nx = ST_RESP;
      default: if (rsp_ready) state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      held_fw    <= 1'b0;
      held_write <= 1'b0;
      held_seg   <= '0;
      held_size  <= '0;
      rsp_ok     <= 1'b0;
      rsp_addr   <= '0;
    end else begin
      state <= state_nx;
      if (take) begin
        held_fw    <= in_fw;
        held_write <= req_write;
        held_seg   <= chk_seg;
        held_size  <= req_size;
        rsp_ok     <= chk_ok;
        rsp_addr   <= chk_xaddr;
      end
    end
  end

  assert_cfg_only_fw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (held_fw && rsp_ok));
  assert_rsz_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rsz |-> !held_write);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ok) && $stable(rsp_addr)));
  assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid || rsp_valid) |-> !req_ready);
endmodule

// File: rtl/lpc_window_xlate.sv
module lpc_window_xlate
  import lpcw_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned SIZE_W        = 3,
  parameter int unsigned IO_SPAN_LOG2  = 16,
  parameter int unsigned MEM_SPAN_LOG2 = 28,
  parameter int unsigned SEG_LOG2      = 28,
  parameter int unsigned RSZ_LSB       = 24,
  parameter logic [ADDR_W-1:0] IO_BASE  = 'hD001_0000,
  parameter logic [ADDR_W-1:0] MEM_BASE = 'hE000_0000,
  parameter logic [ADDR_W-1:0] FW_BASE  = 'hF000_0000,
  parameter logic [ADDR_W-1:0] REG_BASE = 'hC001_2000,
  parameter logic [ADDR_W-1:0] SEG_OFS  = 'h24,
  parameter logic [ADDR_W-1:0] RSZ_OFS  = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [ADDR_W-1:0] cfg_data,
  output logic [ADDR_W-1:0] cfg_mask,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int unsigned SEG_W = ADDR_W - SEG_LOG2;

  logic              chk_ok;
  logic [ADDR_W-1:0] chk_xaddr;
  logic [SEG_W-1:0]  chk_seg, want_seg;
  logic [SIZE_W-1:0] want_size;
  logic              seg_need, rsz_need, seg_load, rsz_load, sel_rsz;

  lpcw_check #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IO_SPAN_LOG2(IO_SPAN_LOG2),
    .MEM_SPAN_LOG2(MEM_SPAN_LOG2), .SEG_LOG2(SEG_LOG2),
    .IO_BASE(IO_BASE), .MEM_BASE(MEM_BASE), .FW_BASE(FW_BASE)
  ) u_check (
    .space(req_space), .addr(req_addr), .size(req_size),
    .ok(chk_ok), .xaddr(chk_xaddr), .seg(chk_seg)
  );

  lpcw_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEG_W(SEG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_size(req_size), .req_write(req_write), .chk_ok(chk_ok),
    .chk_xaddr(chk_xaddr), .chk_seg(chk_seg), .seg_need(seg_need),
    .rsz_need(rsz_need), .cfg_ready(cfg_ready), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .cfg_valid(cfg_valid), .sel_rsz(sel_rsz),
    .seg_load(seg_load), .rsz_load(rsz_load), .want_seg(want_seg),
    .want_size(want_size), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_addr(rsp_addr)
  );

  lpcw_cfg_cache #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEG_W(SEG_W), .RSZ_LSB(RSZ_LSB),
    .REG_BASE(REG_BASE), .SEG_OFS(SEG_OFS), .RSZ_OFS(RSZ_OFS)
  ) u_cache (
    .clk(clk), .rst_n(rst_n), .seg_want(want_seg), .rsz_want(want_size),
    .seg_load(seg_load), .rsz_load(rsz_load), .sel_rsz(sel_rsz),
    .seg_need(seg_need), .rsz_need(rsz_need), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_mask(cfg_mask)
  );

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) && $stable(cfg_data) && $stable(cfg_mask)));
  assert_one_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_valid, rsp_valid}));
endmodule

// File: tb/lpc_window_xlate_bench.sv
module lpc_window_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, cfg_ready = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  req_space = '0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_ready, cfg_valid, rsp_valid, rsp_ok;
  logic [31:0] cfg_addr, cfg_data, cfg_mask, rsp_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] m_seg = 8'hFF, m_rsz = 8'hFF;

  always #5 clk = ~clk;

  lpc_window_xlate u_lpc_window_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_mask(cfg_mask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_addr(rsp_addr)
  );

  task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_addr(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'h0000_FFFF;   3: return 32'h0000_FFFE;
      4: return 32'h0000_FFFC;   5: return 32'h0001_0000;
      6: return 32'h0FFF_FFFF;   7: return 32'h0FFF_FFFE;
      8: return 32'h0FFF_FFFC;   9: return 32'h1000_0000;
      10: return 32'h1FFF_FFFD;  11: return 32'h2FFF_FFFF;
      12: return 32'hFFFF_FFFC;  13: return 32'hFFFF_FFFD;
      14: return 32'hFFFF_FFFF;  15: return 32'h7000_0010;
      default: return 32'h3000_0000;
    endcase
  endfunction

  task automatic run(input logic [1:0] sp, input logic [31:0] a, input logic [2:0] sz,
                     input bit w, input bit stall);
    longint unsigned top;
    bit ok;
    logic [31:0] xa;
    string tag;
    int n_exp, n_got, cyc;
    logic [31:0] e_addr[2], e_data[2], e_mask[2];
    string e_tag[2];
    bit done, r, held_c, held_r;
    logic [31:0] s_ca, s_cd, s_ra;
    logic s_ok;
    top = longint'(a) + longint'(sz);
    ok = 0;
    case (sp)
      2'd0: ok = (sz == 1) && (top <= 64'h1_0000);
      2'd1: ok = (sz == 1) && (top <= 64'h1000_0000);
      2'd2: ok = (sz == 1 || sz == 2 || sz == 4) && (((top - 1) >> 28) == (longint'(a) >> 28));
      default: ok = 0;
    endcase
    if (top > 64'hFFFF_FFFF) ok = 0;
    xa = 32'h0;
    if (ok) xa = (sp == 0) ? 32'hD001_0000 + a : (sp == 1) ? 32'hE000_0000 + a : 32'hF000_0000 + a;
    if (top > 64'hFFFF_FFFF) tag = "R1";
    else if (sp == 0) tag = "R2";
    else if (sp == 1) tag = "R3";
    else if (sp == 3) tag = "R9";
    else if (!(sz == 1 || sz == 2 || sz == 4)) tag = "R5";
    else tag = "R4";
    n_exp = 0;
    if (ok && sp == 2) begin
      if (m_seg != {4'h0, a[31:28]}) begin
        e_addr[n_exp] = 32'hC001_2024; e_data[n_exp] = {28'h0, a[31:28]};
        e_mask[n_exp] = 32'h0000_000F; e_tag[n_exp] = "R6";
        n_exp++; m_seg = {4'h0, a[31:28]};
      end
      if (!w && m_rsz != {5'h0, sz}) begin
        e_addr[n_exp] = 32'hC001_2028;
        e_data[n_exp] = (sz == 1) ? 32'h0 : (sz == 2) ? 32'h0100_0000 : 32'h0200_0000;
        e_mask[n_exp] = 32'hFFFF_FFFF; e_tag[n_exp] = (n_exp == 1) ? "R8" : "R7";
        n_exp++; m_rsz = {5'h0, sz};
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 idle ready", 64'(req_ready), 64'h1);
    req_valid = 1'b1; req_space = sp; req_addr = a; req_size = sz; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    n_got = 0; done = 0; cyc = 0; held_c = 0; held_r = 0;
    while (!done && cyc < 40) begin
      r = stall ? (cyc % 3 == 2) : 1'b1;
      cfg_ready = r; rsp_ready = r;
      chk(!req_ready, "R11 busy ready", 64'(req_ready), 64'h0);
      if (held_c) chk(cfg_valid && cfg_addr == s_ca && cfg_data == s_cd, "R11 cfg hold", {cfg_addr, cfg_data}, {s_ca, s_cd});
      if (held_r) chk(rsp_valid && rsp_addr == s_ra && rsp_ok == s_ok, "R11 rsp hold", {rsp_ok, rsp_addr}, {s_ok, s_ra});
      held_c = 0; held_r = 0;
      if (cfg_valid) begin
        if (r) begin
          if (n_got < n_exp)
            chk(cfg_addr == e_addr[n_got] && cfg_data == e_data[n_got] && cfg_mask == e_mask[n_got],
                e_tag[n_got], {cfg_addr, cfg_data}, {e_addr[n_got], e_data[n_got]});
          else chk(1'b0, "R9 extra cfg", 64'(cfg_addr), 64'h0);
          n_got++;
        end else begin held_c = 1; s_ca = cfg_addr; s_cd = cfg_data; end
      end
      if (rsp_valid) begin
        if (r) begin
          chk(n_got == n_exp, "R8 cfg count", 64'(n_got), 64'(n_exp));
          chk(rsp_ok == ok && rsp_addr == xa, tag, {31'h0, rsp_ok, rsp_addr}, {31'h0, ok, xa});
          done = 1;
        end else begin held_r = 1; s_ra = rsp_addr; s_ok = rsp_ok; end
      end
      @(negedge clk);
      cyc++;
    end
    chk(done, "R11 response seen", 64'(done), 64'h1);
    cfg_ready = 1'b0; rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'h1);
    chk(cfg_valid == 1'b0 && rsp_valid == 1'b0, "R10 reset valids", {cfg_valid, rsp_valid}, 64'h0);
    // R10: first firmware read after reset writes both registers (cache 0xFF)
    run(2'd2, 32'h0000_0000, 3'd1, 1'b0, 1'b0);
    // R7: firmware write with a new size leaves the read-size register alone
    run(2'd2, 32'h0000_0010, 3'd4, 1'b1, 1'b0);
    // R9: reserved space, then a firmware read that must find caches untouched
    run(2'd3, 32'h5000_0000, 3'd1, 1'b0, 1'b0);
    run(2'd2, 32'h0000_0020, 3'd1, 1'b0, 1'b1);
    for (int sp = 0; sp < 4; sp++)
      for (int ai = 0; ai < 17; ai++)
        for (int sz = 0; sz < 8; sz++)
          for (int w = 0; w < 2; w++)
            run(sp[1:0], pick_addr(ai), sz[2:0], w[0], (ai % 4) == 3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule